// File: doc/BRIEF.md
# AHB Wait-State Protocol Monitor

This block is a passive observer for a single-manager AHB bus. It drives nothing on the bus. It samples the manager and subordinate signals on every rising clock edge and keeps a one-cycle copy of them. Whenever the previous edge saw the ready line low, meaning the current transfer was being stretched by wait states, it compares the present values against that copy.

Each class of rule has its own sticky error flag:

- write-data stability,
- legal transfer-type changes,
- address and control stability,
- the two-cycle error response.

A registered pulse marks every cycle in which at least one rule was broken.

Integration is a matter of tapping the bus and routing the flags to a debug or interrupt collector. A synchronous active-low reset clears all history and flags.

The read-data and exclusive-okay lines are deliberately not inputs. No waited-transfer rule restricts them: they only matter in a ready-high cycle, and checking data values is not this block's job.

Top module: `ahb_wait_checker`

## Requirements
- R1: While `rstN` is low at a rising edge, the next sample shows all four error flags and `violation` at 0, and the history resets to: transfer type idle, ready high, response OKAY.
- R2: When the current data phase is a write (accepted with `busWrite`=1 and `busTrans` NONSEQ 2'b10 or SEQ 2'b11) and the previous edge had `busReady`=0, a change of `busWdata` sets `errWdata`.
- R3: Changes of `busWdata` during a read data phase, or after an edge with `busReady`=1, set no flag.
- R4: With the previous edge at `busReady`=0, a change of `busTrans` from IDLE (2'b00) to NONSEQ (2'b10) is legal, and address and control may change in the same cycle.
- R5: With the previous edge at `busReady`=0 and `busBurst` fixed-length (any value other than 3'b000 SINGLE and 3'b001 INCR), BUSY (2'b01) to SEQ (2'b11) is legal. BUSY to any other type sets `errTrans`.
- R6: With the previous edge at `busReady`=0 and `busBurst`=3'b001 (INCR), BUSY may change to any transfer type without a flag.
- R7: After an edge with `busResp`=1 (ERROR) and `busReady`=0, a change of `busTrans` to IDLE is legal, together with address and control changes.
- R8: Any other change of `busTrans` after an edge with `busReady`=0 sets `errTrans`. Example: NONSEQ to IDLE with no error response.
- R9: After an edge with `busReady`=0, a change of `busAddr`, `busWrite`, `busSize` or `busBurst` that is not accompanied by a legal transfer-type change sets `errCtl`.
- R10: An edge with `busResp`=1 and `busReady`=0 must be followed by an edge with `busResp`=1 and `busReady`=1, otherwise `errResp` is set. `busResp`=1 with `busReady`=1 not preceded by that first cycle also sets `errResp`. `busResp` rising while `busReady` is low is not a violation.
- R11: `violation` is registered: it is high exactly in the cycle after an edge where some rule failed. Error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge sampled |
| rstN | input | 1 | Synchronous active-low reset |
| busTrans | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| busAddr | input | ADDR_W | Address of the current address phase |
| busWrite | input | 1 | Write direction of the current address phase |
| busSize | input | 3 | Transfer size |
| busBurst | input | 3 | Burst type (000 single, 001 incrementing undefined length) |
| busWdata | input | DATA_W | Write data bus |
| busReady | input | 1 | Transfer-done line from the subordinate |
| busResp | input | 1 | Response, 1 = ERROR |
| errWdata | output | 1 | Sticky: write data moved during a wait |
| errTrans | output | 1 | Sticky: illegal transfer-type change during a wait |
| errCtl | output | 1 | Sticky: address/control moved without a legal type change |
| errResp | output | 1 | Sticky: malformed two-cycle error response |
| violation | output | 1 | One-cycle pulse for any rule broken at the previous edge |

## Verification
The bench targets the legality table for transfer-type changes:

- BUSY to SEQ inside a fixed burst against BUSY to NONSEQ in the same burst, which a design treating all bursts alike would accept.
- BUSY to anything inside an incrementing burst, which a design that ignored burst type would wrongly flag.
- The error-cycle escape to IDLE, which a design that ignored the response would reject.

It also separates a write data phase from a read one, so that a design that compared write data regardless of direction raises false flags. It checks both halves of the error response: a stuck first cycle, and an orphan second cycle right after reset.

Constrained random traffic then compares every cycle's pulse and flags against a bench model built from the rules.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam int BURST_W = 3;
  localparam int SIZE_W  = 3;
  localparam logic [BURST_W-1:0] BURST_SINGLE = 3'b000;
  localparam logic [BURST_W-1:0] BURST_INCR   = 3'b001;

  localparam int RULE_CNT = 4;

  // Control -> datapath strobes; packed order matches flag index 3..0
  typedef struct packed {
    logic respBad;
    logic ctlBad;
    logic transBad;
    logic wdataBad;
  } ruleHits_t;

endpackage

// File: rtl/ahbw_history.sv
module ahbw_history
  import ahbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  trans_e              trans,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                write,
  input  logic [SIZE_W-1:0]   size,
  input  logic [BURST_W-1:0]  burst,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                ready,
  input  logic                resp,
  input  ruleHits_t           hits,
  output trans_e              prevTrans,
  output logic [BURST_W-1:0]  prevBurst,
  output logic                prevReady,
  output logic                prevResp,
  output logic                wrPending,
  output logic                wdataMoved,
  output logic                ctlMoved,
  output logic [RULE_CNT-1:0] errFlags,
  output logic                violation
);

  localparam int CTL_W = ADDR_W + 1 + SIZE_W + BURST_W;

  logic [CTL_W-1:0]    prevCtl;
  logic [DATA_W-1:0]   prevWdata;
  logic [CTL_W-1:0]    curCtl;
  logic [RULE_CNT-1:0] hitVec;

  assign curCtl = {addr, write, size, burst};
  assign hitVec = hits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTrans <= TR_IDLE;
      prevCtl   <= '0;
      prevWdata <= '0;
      prevReady <= 1'b1;
      prevResp  <= 1'b0;
      wrPending <= 1'b0;
    end else begin
      prevTrans <= trans;
      prevCtl   <= curCtl;
      prevWdata <= wdata;
      prevReady <= ready;
      prevResp  <= resp;
      // data phase advances only on a completed edge
      if (ready) wrPending <= write && trans[1];
    end
  end

  assign prevBurst  = prevCtl[BURST_W-1:0];
  assign wdataMoved = wdata != prevWdata;
  assign ctlMoved   = curCtl != prevCtl;

  for (genvar i = 0; i < RULE_CNT; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)          errFlags[i] <= 1'b0;
      else if (hitVec[i]) errFlags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) violation <= 1'b0;
    else       violation <= |hitVec;
  end

endmodule

// File: rtl/ahbw_rules.sv
module ahbw_rules
  import ahbw_pkg::*;
(
  input  trans_e             trans,
  input  logic               ready,
  input  logic               resp,
  input  trans_e             prevTrans,
  input  logic [BURST_W-1:0] prevBurst,
  input  logic               prevReady,
  input  logic               prevResp,
  input  logic               wrPending,
  input  logic               wdataMoved,
  input  logic               ctlMoved,
  output ruleHits_t          hits
);

  logic waitPrev;
  logic transMoved;
  logic fixedBurst;
  logic legalMove;
  logic errFirst;
  logic errSecond;

  assign waitPrev   = !prevReady;
  assign transMoved = trans != prevTrans;
  assign fixedBurst = (prevBurst != BURST_SINGLE) && (prevBurst != BURST_INCR);
  assign errFirst   = prevResp && !prevReady;
  assign errSecond  = resp && ready;

  always_comb begin
    unique case (prevTrans)
      TR_IDLE: legalMove = (trans == TR_NONSEQ);
      TR_BUSY: legalMove = (prevBurst == BURST_INCR) ||
                           (fixedBurst && trans == TR_SEQ);
      default: legalMove = 1'b0;
    endcase
    if (prevResp && trans == TR_IDLE) legalMove = 1'b1;
  end

  always_comb begin
    hits          = '0;
    hits.wdataBad = waitPrev && wrPending && wdataMoved;
    hits.transBad = waitPrev && transMoved && !legalMove;
    hits.ctlBad   = waitPrev && ctlMoved && !(transMoved && legalMove);
    hits.respBad  = errFirst != errSecond;
  end

endmodule

// File: rtl/ahb_wait_checker.sv
module ahb_wait_checker
  import ahbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busTrans,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [2:0]        busSize,
  input  logic [2:0]        busBurst,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busReady,
  input  logic              busResp,
  output logic              errWdata,
  output logic              errTrans,
  output logic              errCtl,
  output logic              errResp,
  output logic              violation
);

  trans_e              transNow;
  trans_e              prevTrans;
  logic [BURST_W-1:0]  prevBurst;
  logic                prevReady;
  logic                prevResp;
  logic                wrPending;
  logic                wdataMoved;
  logic                ctlMoved;
  logic [RULE_CNT-1:0] errFlags;
  ruleHits_t           hits;

  assign transNow = trans_e'(busTrans);

  ahbw_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hist (
    .clk(clk), .rstN(rstN), .trans(transNow), .addr(busAddr),
    .write(busWrite), .size(busSize), .burst(busBurst), .wdata(busWdata),
    .ready(busReady), .resp(busResp), .hits(hits),
    .prevTrans(prevTrans), .prevBurst(prevBurst), .prevReady(prevReady),
    .prevResp(prevResp), .wrPending(wrPending), .wdataMoved(wdataMoved),
    .ctlMoved(ctlMoved), .errFlags(errFlags), .violation(violation)
  );

  ahbw_rules u_rules (
    .trans(transNow), .ready(busReady), .resp(busResp),
    .prevTrans(prevTrans), .prevBurst(prevBurst), .prevReady(prevReady),
    .prevResp(prevResp), .wrPending(wrPending), .wdataMoved(wdataMoved),
    .ctlMoved(ctlMoved), .hits(hits)
  );

  assign errWdata = errFlags[0];
  assign errTrans = errFlags[1];
  assign errCtl   = errFlags[2];
  assign errResp  = errFlags[3];

endmodule

// File: rtl/ahb_wait_checker_sva.sv
module ahb_wait_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busTrans,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busReady,
  input logic              busResp,
  input logic              wrPending,
  input logic              errWdata,
  input logic              errTrans,
  input logic              errCtl,
  input logic              errResp,
  input logic              violation
);

  logic [3:0] flagVec;
  assign flagVec = {errResp, errCtl, errTrans, errWdata};

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (flagVec == 4'b0 && !violation));

  a_r2_wdata_moved: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && wrPending) ##1 (busWdata != $past(busWdata)) |=> errWdata);

  a_r8_seq_to_nonseq: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && !busResp && busTrans == 2'b11) ##1 (busTrans == 2'b10)
    |=> errTrans);

  a_r9_addr_moved: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && !busResp) ##1
    (busTrans == $past(busTrans) && busAddr != $past(busAddr)) |=> errCtl);

  a_r10_resp_second: assert property (@(posedge clk) disable iff (!rstN)
    (busResp && !busReady) ##1 !(busResp && busReady) |=> errResp);

  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec != 4'b0) |=> ((flagVec & $past(flagVec)) == $past(flagVec)));

  a_r11_pulse_marks_flag: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (flagVec != 4'b0));

endmodule

bind ahb_wait_checker ahb_wait_checker_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rstN(rstN), .busTrans(busTrans), .busAddr(busAddr),
  .busWdata(busWdata), .busReady(busReady), .busResp(busResp),
  .wrPending(wrPending), .errWdata(errWdata), .errTrans(errTrans),
  .errCtl(errCtl), .errResp(errResp), .violation(violation)
);

// File: tb/ahb_wait_checker_tb.sv
module ahb_wait_checker_tb;

  localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;
  localparam logic [2:0] B_INCR = 3'b001, B_INCR4 = 3'b011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  busTrans = IDL;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [2:0]  busSize = '0;
  logic [2:0]  busBurst = '0;
  logic [31:0] busWdata = '0;
  logic        busReady = 1'b1;
  logic        busResp = 1'b0;
  logic errWdata, errTrans, errCtl, errResp, violation;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0]  mT;
  logic [31:0] mA, mD;
  logic        mW, mRdy, mRsp, mPend;
  logic [2:0]  mS, mB;
  logic [3:0]  expFlags;
  logic        expViol;

  always #5 clk = ~clk;

  ahb_wait_checker u_dut (
    .clk(clk), .rstN(rstN), .busTrans(busTrans), .busAddr(busAddr),
    .busWrite(busWrite), .busSize(busSize), .busBurst(busBurst),
    .busWdata(busWdata), .busReady(busReady), .busResp(busResp),
    .errWdata(errWdata), .errTrans(errTrans), .errCtl(errCtl),
    .errResp(errResp), .violation(violation)
  );

  function automatic logic [3:0] ruleHits(input logic [1:0] t, input logic [31:0] a,
      input logic w, input logic [2:0] s, input logic [2:0] b, input logic [31:0] d,
      input logic rdy, input logic rsp);
    logic ok, moved, ctlCh, wd, tr, ct, rs;
    moved = (t != mT);
    ok = 1'b0;
    if (mT == IDL && t == NSQ) ok = 1'b1;
    if (mT == BSY && mB == B_INCR) ok = 1'b1;
    if (mT == BSY && t == SQ && mB != 3'b000 && mB != B_INCR) ok = 1'b1;
    if (mRsp && t == IDL) ok = 1'b1;
    ctlCh = (a != mA) || (w != mW) || (s != mS) || (b != mB);
    wd = !mRdy && mPend && (d != mD);
    tr = !mRdy && moved && !ok;
    ct = !mRdy && ctlCh && !(moved && ok);
    rs = (mRsp && !mRdy) != (rsp && rdy);
    return {rs, ct, tr, wd};
  endfunction

  task automatic modelReset();
    mT = IDL; mA = '0; mD = '0; mW = 0; mS = '0; mB = '0;
    mRdy = 1'b1; mRsp = 1'b0; mPend = 1'b0;
    expFlags = '0; expViol = 1'b0;
  endtask

  task automatic checkOut(input string tag);
    logic [4:0] got, exp;
    got = {violation, errResp, errCtl, errTrans, errWdata};
    exp = {expViol, expFlags};
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got viol/flags=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] t, input logic [31:0] a, input logic w,
      input logic [2:0] s, input logic [2:0] b, input logic [31:0] d,
      input logic rdy, input logic rsp, input string tag, input bit doCheck);
    logic [3:0] h;
    @(negedge clk);
    busTrans = t; busAddr = a; busWrite = w; busSize = s; busBurst = b;
    busWdata = d; busReady = rdy; busResp = rsp;
    h = ruleHits(t, a, w, s, b, d, rdy, rsp);
    expFlags = expFlags | h;
    expViol = |h;
    if (rdy) mPend = w && t[1];
    mT = t; mA = a; mW = w; mS = s; mB = b; mD = d; mRdy = rdy; mRsp = rsp;
    @(posedge clk);
    #2;
    if (doCheck) checkOut(tag);
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    rstN = 1'b0;
    busTrans = IDL; busReady = 1'b1; busResp = 1'b0;
    busAddr = '0; busWrite = 0; busSize = '0; busBurst = '0; busWdata = '0;
    repeat (2) @(posedge clk);
    #2;
    modelReset();
    checkOut(tag);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic expectBit(input string tag, input logic got, input logic exp);
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    doReset("R1 reset state");

    // R2: write data phase stretched, data moves
    cyc(NSQ, 32'h100, 1, 3'd2, B_INCR4, 32'h5, 1, 0, "R2 addr", 1);
    cyc(IDL, 32'h100, 1, 3'd2, B_INCR4, 32'h5, 0, 0, "R2 wait", 1);
    cyc(IDL, 32'h100, 1, 3'd2, B_INCR4, 32'h6, 0, 0, "R2 moved", 1);
    expectBit("R2 errWdata", errWdata, 1'b1);
    // R11: pulse drops, flag stays
    cyc(IDL, 32'h100, 1, 3'd2, B_INCR4, 32'h6, 1, 0, "R11 hold", 1);
    expectBit("R11 pulse low", violation, 1'b0);
    expectBit("R11 sticky", errWdata, 1'b1);

    // R3: read phase wdata churn, ready-high churn
    doReset("R1 reset again");
    cyc(NSQ, 32'h200, 0, 3'd2, B_INCR4, 32'h1, 1, 0, "R3 read addr", 1);
    cyc(IDL, 32'h200, 0, 3'd2, B_INCR4, 32'h2, 0, 0, "R3 wait", 1);
    cyc(IDL, 32'h200, 0, 3'd2, B_INCR4, 32'h3, 0, 0, "R3 read churn", 1);
    cyc(IDL, 32'h200, 0, 3'd2, B_INCR4, 32'h4, 1, 0, "R3 end", 1);
    cyc(IDL, 32'h200, 0, 3'd2, B_INCR4, 32'h9, 1, 0, "R3 ready churn", 1);
    expectBit("R3 errWdata clear", errWdata, 1'b0);

    // R4: IDLE -> NONSEQ during wait with new address
    cyc(IDL, 32'h300, 1, 3'd2, B_INCR4, 32'h0, 0, 0, "R4 wait", 1);
    cyc(NSQ, 32'h340, 0, 3'd1, B_INCR, 32'h0, 0, 0, "R4 legal", 1);
    expectBit("R4 no trans err", errTrans | errCtl, 1'b0);

    // R5: fixed burst BUSY -> SEQ legal, BUSY -> NONSEQ illegal
    doReset("R1 reset R5");
    cyc(BSY, 32'h400, 1, 3'd2, B_INCR4, 32'h0, 0, 0, "R5 busy", 1);
    cyc(SQ,  32'h400, 1, 3'd2, B_INCR4, 32'h0, 0, 0, "R5 seq legal", 1);
    expectBit("R5 legal clean", errTrans, 1'b0);
    doReset("R1 reset R5b");
    cyc(BSY, 32'h400, 1, 3'd2, B_INCR4, 32'h0, 0, 0, "R5 busy", 1);
    cyc(NSQ, 32'h400, 1, 3'd2, B_INCR4, 32'h0, 0, 0, "R5 nonseq bad", 1);
    expectBit("R5 errTrans", errTrans, 1'b1);

    // R6: INCR burst BUSY -> NONSEQ with new addr
    doReset("R1 reset R6");
    cyc(BSY, 32'h500, 1, 3'd2, B_INCR, 32'h0, 0, 0, "R6 busy", 1);
    cyc(NSQ, 32'h600, 1, 3'd2, B_INCR, 32'h0, 0, 0, "R6 legal", 1);
    expectBit("R6 clean", errTrans | errCtl, 1'b0);

    // R7 + R10: resp rises during wait, error completes, move to IDLE
    doReset("R1 reset R7");
    cyc(NSQ, 32'h700, 0, 3'd2, B_INCR4, 32'h0, 0, 0, "R10 wait ok", 1);
    cyc(NSQ, 32'h700, 0, 3'd2, B_INCR4, 32'h0, 0, 1, "R10 resp rise", 1);
    cyc(IDL, 32'h0,   1, 3'd0, 3'd0,    32'h0, 1, 1, "R7 idle legal", 1);
    expectBit("R7 clean", errTrans | errCtl | errResp, 1'b0);

    // R8: NONSEQ -> IDLE without error
    doReset("R1 reset R8");
    cyc(NSQ, 32'h800, 0, 3'd2, B_INCR4, 32'h0, 0, 0, "R8 wait", 1);
    cyc(IDL, 32'h800, 0, 3'd2, B_INCR4, 32'h0, 0, 0, "R8 bad", 1);
    expectBit("R8 errTrans", errTrans, 1'b1);

    // R9: address moves, type held
    doReset("R1 reset R9");
    cyc(NSQ, 32'h900, 0, 3'd2, B_INCR4, 32'h0, 0, 0, "R9 wait", 1);
    cyc(NSQ, 32'h904, 0, 3'd2, B_INCR4, 32'h0, 0, 0, "R9 addr bad", 1);
    expectBit("R9 errCtl", errCtl, 1'b1);
    doReset("R1 reset R9b");
    cyc(SQ, 32'h900, 0, 3'd2, B_INCR4, 32'h0, 0, 0, "R9 wait", 1);
    cyc(SQ, 32'h900, 0, 3'd1, B_INCR4, 32'h0, 0, 0, "R9 size bad", 1);
    expectBit("R9 errCtl size", errCtl, 1'b1);

    // R10: stuck first cycle, orphan second cycle
    doReset("R1 reset R10");
    cyc(NSQ, 32'hA00, 0, 3'd2, B_INCR4, 32'h0, 0, 1, "R10 first", 1);
    cyc(NSQ, 32'hA00, 0, 3'd2, B_INCR4, 32'h0, 0, 1, "R10 stuck", 1);
    expectBit("R10 errResp", errResp, 1'b1);
    doReset("R1 reset R10b");
    cyc(IDL, 32'h0, 0, 3'd0, 3'd0, 32'h0, 1, 1, "R10 orphan", 1);
    expectBit("R10 orphan errResp", errResp, 1'b1);

    // random traffic, model compared every cycle
    for (int blk = 0; blk < 8; blk++) begin
      doReset("R1 reset random");
      for (int i = 0; i < 60; i++) begin
        logic [1:0] t; logic [31:0] a, d; logic w, rdy, rsp; logic [2:0] s, b;
        t = mT; a = mA; w = mW; s = mS; b = mB; d = mD;
        if ($urandom_range(3) == 0) t = 2'($urandom_range(3));
        if ($urandom_range(7) == 0) a = a + 32'd4;
        if ($urandom_range(15) == 0) w = ~w;
        if ($urandom_range(3) == 0) b = ($urandom_range(1) == 0) ? B_INCR : B_INCR4;
        if ($urandom_range(5) == 0) d = $urandom;
        rdy = ($urandom_range(9) < 6);
        rsp = (mRsp && !mRdy) ? ($urandom_range(7) != 0) : ($urandom_range(15) == 0);
        if (mRsp && !mRdy && rsp) rdy = ($urandom_range(7) != 0);
        cyc(t, a, w, s, b, d, rdy, rsp, "R11 random", 1);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule